// File: doc/BRIEF.md
# Paged write buffer controller

This block sits behind a two-wire serial slave engine and gathers the data bytes of one write transaction into a small page buffer. Each data byte lands in the slot chosen by the low bits of a shared address pointer. After each byte only those low bits advance, so a burst longer than the page folds back and replaces bytes it sent earlier. A bitmask records which slots hold fresh data.

When the bus STOP closes a transaction that holds at least one buffered byte, the block enters one timed program cycle. During that cycle it raises a busy flag for a programmable number of system clocks. In the first clocks of the cycle it walks through the slots and presents one write on the memory port for each slot marked valid. A repeated START or a read header that arrives before STOP throws the buffer away. While busy, every bus-side input is ignored. When the cycle ends, the mask is cleared and the pointer rests one past the last slot written.

Top module: `pgwr_ctrl`

## Requirements
- R1: After reset, `busy_o` is 0, `mem_we_o` is 0 and `ptr_o` is 0.
- R2: A data byte accepted while idle is stored in the slot `ptr_o[3:0]`. Afterwards `ptr_o[3:0]` increases by one, wrapping from 15 to 0, and `ptr_o[7:4]` is unchanged.
- R3: A STOP seen while idle with at least one buffered byte (a byte given in the same cycle counts) raises `busy_o` from the next cycle. `busy_o` then stays high for exactly `WRITE_CYCLES` cycles.
- R4: During a program cycle, each valid slot is written exactly once at address `{ptr_o[7:4], slot}` with the last byte stored in it. Slots that are not valid are not written, and `mem_we_o` is never high while `busy_o` is low.
- R5: When more than 16 bytes arrive before STOP, later bytes overwrite the earlier slots of the same page, and only the final value of each slot is written.
- R6: A START or a read header seen while idle discards every buffered byte, including a data byte given in the same cycle. A following STOP then starts no program cycle and makes no write.
- R7: A STOP with no buffered byte leaves `busy_o` low and makes no write.
- R8: While `busy_o` is high, the data, address load, START, STOP and read header inputs have no effect. `ptr_o` holds, no extra write occurs, and the busy length is unchanged.
- R9: After a program cycle, `ptr_o` points one past the last slot written within the page, and the valid mask is empty, so a bare STOP starts no new cycle.
- R10: An address load while idle sets `ptr_o` only if no byte is buffered. Otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | START or repeated START detected (one-cycle pulse) |
| stop_i | input | 1 | STOP detected (one-cycle pulse) |
| rd_hdr_i | input | 1 | Read header accepted (one-cycle pulse) |
| addr_ld_i | input | 1 | Byte address received, load pointer |
| addr_i | input | 8 | Byte address value |
| data_vld_i | input | 1 | Data byte received |
| data_i | input | 8 | Data byte value |
| busy_o | output | 1 | Program cycle in progress |
| ptr_o | output | 8 | Shared address pointer |
| mem_we_o | output | 1 | Memory array write enable |
| mem_addr_o | output | 8 | Memory array write address |
| mem_wdata_o | output | 8 | Memory array write data |

## Verification
Two pairs of events can fall in the same clock. The last data byte can coincide with STOP; that byte must still be part of the commit. A START can coincide with a data byte; the discard must win. The bench drives each pair in a single cycle, then judges the result from the number of writes, the written values and whether `busy_o` rose. A third collision puts new bytes, STOP and START on the bus in the middle of a program cycle. The bench then checks that the busy length and the write count match those of the original transaction alone.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
   typedef enum logic {
      PG_IDLE = 1'b0,
      PG_PROG = 1'b1
   } pg_state_e;
endpackage

// File: rtl/pgwr_ptr.sv
module pgwr_ptr #(
   parameter int ADDR_W = 8,
   parameter int PAGE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_addr_i,
   input  logic              step_i,
   output logic [ADDR_W-1:0] ptr_o
);
   localparam int HI_W = ADDR_W - PAGE_W;

   logic [HI_W-1:0]   page_q;
   logic [PAGE_W-1:0] slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
         slot_q <= '0;
      end else if (load_i) begin
         page_q <= load_addr_i[ADDR_W-1:PAGE_W];
         slot_q <= load_addr_i[PAGE_W-1:0];
      end else if (step_i) begin
         slot_q <= slot_q + PAGE_W'(1);
      end
   end

   assign ptr_o = {page_q, slot_q};
endmodule

// File: rtl/pgwr_slots.sv
module pgwr_slots #(
   parameter int PAGE_W = 4,
   parameter int DATA_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_i,
   input  logic [PAGE_W-1:0]      wr_slot_i,
   input  logic [DATA_W-1:0]      wr_data_i,
   input  logic                   drop_i,
   input  logic [PAGE_W-1:0]      rd_slot_i,
   output logic [DATA_W-1:0]      rd_data_o,
   output logic                   rd_valid_o,
   output logic [(1<<PAGE_W)-1:0] mask_o
);
   localparam int SLOTS = 1 << PAGE_W;

   logic [DATA_W-1:0] slot_data [SLOTS];

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      logic [DATA_W-1:0] byte_q;
      logic              vld_q;
      logic              hit;

      assign hit = wr_i && (wr_slot_i == PAGE_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
         end else if (drop_i) begin
            vld_q <= 1'b0;
         end else if (hit) begin
            vld_q <= 1'b1;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_q <= '0;
         end else if (hit && !drop_i) begin
            byte_q <= wr_data_i;
         end
      end

      assign slot_data[g] = byte_q;
      assign mask_o[g]    = vld_q;
   end

   assign rd_data_o  = slot_data[rd_slot_i];
   assign rd_valid_o = mask_o[rd_slot_i];
endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer
   import pgwr_pkg::*;
#(
   parameter int WRITE_CYCLES = 400000,
   parameter int PAGE_W       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   output logic              busy_o,
   output logic              scan_en_o,
   output logic [PAGE_W-1:0] scan_slot_o,
   output logic              done_o
);
   localparam int CYC_W = $clog2(WRITE_CYCLES + 1);
   localparam int SLOTS = 1 << PAGE_W;

   pg_state_e        state_q;
   logic [CYC_W-1:0] cnt_q;

   assign busy_o      = (state_q == PG_PROG);
   assign done_o      = busy_o && (cnt_q == CYC_W'(WRITE_CYCLES - 1));
   assign scan_en_o   = busy_o && (cnt_q < CYC_W'(SLOTS));
   assign scan_slot_o = cnt_q[PAGE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PG_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            PG_IDLE: begin
               cnt_q <= '0;
               if (go_i) state_q <= PG_PROG;
            end
            PG_PROG: begin
               if (done_o) begin
                  state_q <= PG_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + CYC_W'(1);
               end
            end
            default: state_q <= PG_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl #(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 8,
   parameter int PAGE_W       = 4,
   parameter int WRITE_CYCLES = 400000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              rd_hdr_i,
   input  logic              addr_ld_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              data_vld_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              busy_o,
   output logic [ADDR_W-1:0] ptr_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o
);
   localparam int SLOTS = 1 << PAGE_W;

   if (ADDR_W <= PAGE_W) begin : g_bad_addr
      $error("pgwr_ctrl: ADDR_W must exceed PAGE_W");
   end
   if (WRITE_CYCLES < SLOTS) begin : g_bad_cycles
      $error("pgwr_ctrl: WRITE_CYCLES must cover one slot scan");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("pgwr_ctrl: DATA_W must be positive");
   end

   logic             idle;
   logic             drop;
   logic             take;
   logic             load;
   logic             go;
   logic             done;
   logic             scan_en;
   logic [PAGE_W-1:0] scan_slot;
   logic [DATA_W-1:0] scan_data;
   logic             scan_vld;
   logic [SLOTS-1:0] slot_mask;

   assign idle = !busy_o;
   assign drop = (idle && (start_i || rd_hdr_i)) || done;
   assign take = idle && data_vld_i && !start_i && !rd_hdr_i;
   assign load = idle && addr_ld_i && (slot_mask == '0) && !take;
   assign go   = idle && stop_i && !start_i && !rd_hdr_i
                 && ((slot_mask != '0) || take);

   pgwr_ptr #(
      .ADDR_W (ADDR_W),
      .PAGE_W (PAGE_W)
   ) u_ptr (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (load),
      .load_addr_i (addr_i),
      .step_i      (take),
      .ptr_o       (ptr_o)
   );

   pgwr_slots #(
      .PAGE_W (PAGE_W),
      .DATA_W (DATA_W)
   ) u_slots (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (take),
      .wr_slot_i  (ptr_o[PAGE_W-1:0]),
      .wr_data_i  (data_i),
      .drop_i     (drop),
      .rd_slot_i  (scan_slot),
      .rd_data_o  (scan_data),
      .rd_valid_o (scan_vld),
      .mask_o     (slot_mask)
   );

   pgwr_timer #(
      .WRITE_CYCLES (WRITE_CYCLES),
      .PAGE_W       (PAGE_W)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .go_i        (go),
      .busy_o      (busy_o),
      .scan_en_o   (scan_en),
      .scan_slot_o (scan_slot),
      .done_o      (done)
   );

   assign mem_we_o    = scan_en && scan_vld;
   assign mem_addr_o  = {ptr_o[ADDR_W-1:PAGE_W], scan_slot};
   assign mem_wdata_o = scan_data;
endmodule

// File: rtl/pgwr_ctrl_chk.sv
module pgwr_ctrl_chk #(
   parameter int ADDR_W       = 8,
   parameter int PAGE_W       = 4,
   parameter int WRITE_CYCLES = 400000
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   start_i,
   input logic                   stop_i,
   input logic                   rd_hdr_i,
   input logic                   addr_ld_i,
   input logic                   data_vld_i,
   input logic                   busy_o,
   input logic [ADDR_W-1:0]      ptr_o,
   input logic                   mem_we_o,
   input logic [(1<<PAGE_W)-1:0] mask_i
);
   logic [31:0] busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_len <= '0;
      else if (busy_o) busy_len <= busy_len + 32'd1;
      else busy_len <= '0;
   end

   AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> busy_o); // R4

   AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(stop_i)); // R3

   AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (busy_len == 32'(WRITE_CYCLES))); // R3

   AST_PTR_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(ptr_o)); // R8

   AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (data_vld_i && !busy_o && !start_i && !rd_hdr_i && !addr_ld_i)
      |=> (ptr_o[ADDR_W-1:PAGE_W] == $past(ptr_o[ADDR_W-1:PAGE_W]))
          && (ptr_o[PAGE_W-1:0] == $past(ptr_o[PAGE_W-1:0]) + PAGE_W'(1))); // R2

   AST_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && (start_i || rd_hdr_i)) |=> (mask_i == '0) && !busy_o); // R6

   AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (mask_i == '0)); // R9
endmodule

bind pgwr_ctrl pgwr_ctrl_chk #(
   .ADDR_W       (ADDR_W),
   .PAGE_W       (PAGE_W),
   .WRITE_CYCLES (WRITE_CYCLES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .stop_i     (stop_i),
   .rd_hdr_i   (rd_hdr_i),
   .addr_ld_i  (addr_ld_i),
   .data_vld_i (data_vld_i),
   .busy_o     (busy_o),
   .ptr_o      (ptr_o),
   .mem_we_o   (mem_we_o),
   .mask_i     (slot_mask)
);

// File: tb/pgwr_ctrl_bench.sv
module pgwr_ctrl_bench;
   localparam int WC = 200;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0, stop_i = 1'b0, rd_hdr_i = 1'b0;
   logic       addr_ld_i = 1'b0, data_vld_i = 1'b0;
   logic [7:0] addr_i = '0, data_i = '0;
   logic       busy_o, mem_we_o;
   logic [7:0] ptr_o, mem_addr_o, mem_wdata_o;

   int tests = 0, fails = 0;
   int wr_total = 0, busy_total = 0;
   logic [7:0] shadow [256];

   always #5 clk = ~clk;

   pgwr_ctrl #(.WRITE_CYCLES(WC)) u_pgwr_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
      .rd_hdr_i(rd_hdr_i), .addr_ld_i(addr_ld_i), .addr_i(addr_i),
      .data_vld_i(data_vld_i), .data_i(data_i), .busy_o(busy_o),
      .ptr_o(ptr_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o)
   );

   always @(posedge clk) begin
      if (mem_we_o) begin
         wr_total++;
         shadow[mem_addr_o] = mem_wdata_o;
      end
      if (busy_o) busy_total++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic give_addr(input logic [7:0] a);
      @(negedge clk); addr_ld_i = 1'b1; addr_i = a;
      @(negedge clk); addr_ld_i = 1'b0;
   endtask

   task automatic give_byte(input logic [7:0] d);
      @(negedge clk); data_vld_i = 1'b1; data_i = d;
      @(negedge clk); data_vld_i = 1'b0;
   endtask

   task automatic give_stop();
      @(negedge clk); stop_i = 1'b1;
      @(negedge clk); stop_i = 1'b0;
   endtask

   task automatic give_start();
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
   endtask

   task automatic give_rdhdr();
      @(negedge clk); rd_hdr_i = 1'b1;
      @(negedge clk); rd_hdr_i = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 5000 && busy_o; i++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
      chk(mem_we_o == 1'b0, "R1 we", mem_we_o, 0);
      chk(ptr_o == 8'h00, "R1 ptr", ptr_o, 0);
   endtask

   task automatic t_page();
      int w0 = wr_total, b0 = busy_total;
      give_addr(8'h35);
      for (int i = 0; i < 5; i++) give_byte(8'hA0 + 8'(i));
      chk(ptr_o == 8'h3A, "R2 ptr step", ptr_o, 8'h3A);
      give_stop();
      chk(busy_o == 1'b1, "R3 busy rise", busy_o, 1);
      wait_idle();
      chk(busy_total - b0 == WC, "R3 busy length", busy_total - b0, WC);
      chk(wr_total - w0 == 5, "R4 write count", wr_total - w0, 5);
      for (int i = 0; i < 5; i++)
         chk(shadow[8'h35 + 8'(i)] === 8'hA0 + 8'(i), "R4 data",
             shadow[8'h35 + 8'(i)], 8'hA0 + i);
      chk(ptr_o == 8'h3A, "R9 ptr after commit", ptr_o, 8'h3A);
   endtask

   task automatic t_wrap();
      int w0 = wr_total;
      give_addr(8'h70);
      for (int i = 0; i < 18; i++) give_byte(8'h40 + 8'(i));
      give_stop();
      wait_idle();
      chk(wr_total - w0 == 16, "R5 write count", wr_total - w0, 16);
      chk(shadow[8'h70] === 8'h50, "R5 slot0 overwritten", shadow[8'h70], 8'h50);
      chk(shadow[8'h71] === 8'h51, "R5 slot1 overwritten", shadow[8'h71], 8'h51);
      chk(shadow[8'h7F] === 8'h4F, "R5 slot15 kept", shadow[8'h7F], 8'h4F);
      chk(ptr_o == 8'h72, "R9 ptr after wrap", ptr_o, 8'h72);
   endtask

   task automatic t_page_edge();
      int w0 = wr_total;
      give_addr(8'hFE);
      give_byte(8'hC1); give_byte(8'hC2); give_byte(8'hC3);
      chk(ptr_o == 8'hF1, "R2 low wrap upper fixed", ptr_o, 8'hF1);
      give_stop();
      wait_idle();
      chk(wr_total - w0 == 3, "R2 write count", wr_total - w0, 3);
      chk(shadow[8'hF0] === 8'hC3, "R2 wrapped slot", shadow[8'hF0], 8'hC3);
      chk(shadow[8'hFF] === 8'hC2, "R2 top slot", shadow[8'hFF], 8'hC2);
   endtask

   task automatic t_discard();
      int w0 = wr_total;
      give_addr(8'h10);
      give_byte(8'hEE); give_byte(8'hEF);
      give_start();
      give_stop();
      chk(busy_o == 1'b0, "R6 start discard busy", busy_o, 0);
      give_addr(8'h18);
      give_byte(8'hED);
      give_rdhdr();
      give_stop();
      chk(busy_o == 1'b0, "R6 read header discard busy", busy_o, 0);
      // byte and START in the same cycle: discard wins
      give_addr(8'h40);
      @(negedge clk); data_vld_i = 1'b1; data_i = 8'hDD; start_i = 1'b1;
      @(negedge clk); data_vld_i = 1'b0; start_i = 1'b0;
      give_stop();
      chk(busy_o == 1'b0, "R6 coincident start busy", busy_o, 0);
      repeat (20) @(negedge clk);
      chk(wr_total - w0 == 0, "R6 no writes", wr_total - w0, 0);
   endtask

   task automatic t_empty_stop();
      int w0 = wr_total;
      give_stop();
      chk(busy_o == 1'b0, "R7 R9 empty stop", busy_o, 0);
      repeat (20) @(negedge clk);
      chk(wr_total - w0 == 0, "R7 no writes", wr_total - w0, 0);
   endtask

   task automatic t_busy_ignore();
      int w0 = wr_total, b0 = busy_total;
      give_addr(8'h00);
      give_byte(8'h11);
      give_stop();
      repeat (30) @(negedge clk);
      give_addr(8'h90);
      give_byte(8'h99);
      give_stop();
      give_start();
      chk(ptr_o == 8'h01, "R8 ptr held", ptr_o, 1);
      wait_idle();
      chk(busy_total - b0 == WC, "R8 busy length", busy_total - b0, WC);
      chk(wr_total - w0 == 1, "R8 write count", wr_total - w0, 1);
      chk(shadow[8'h00] === 8'h11, "R8 data", shadow[8'h00], 8'h11);
      chk(busy_o == 1'b0, "R8 no second cycle", busy_o, 0);
   endtask

   task automatic t_coincide();
      int w0 = wr_total;
      give_addr(8'h60);
      give_byte(8'h21);
      @(negedge clk); data_vld_i = 1'b1; data_i = 8'h22; stop_i = 1'b1;
      @(negedge clk); data_vld_i = 1'b0; stop_i = 1'b0;
      chk(busy_o == 1'b1, "R3 stop with last byte", busy_o, 1);
      wait_idle();
      chk(wr_total - w0 == 2, "R4 coincident count", wr_total - w0, 2);
      chk(shadow[8'h61] === 8'h22, "R4 coincident byte", shadow[8'h61], 8'h22);
   endtask

   task automatic t_addr_pending();
      int w0 = wr_total;
      give_addr(8'h20);
      give_byte(8'h31);
      give_addr(8'h50);
      chk(ptr_o == 8'h21, "R10 load ignored", ptr_o, 8'h21);
      give_byte(8'h32);
      give_stop();
      wait_idle();
      chk(wr_total - w0 == 2, "R10 write count", wr_total - w0, 2);
      chk(shadow[8'h21] === 8'h32, "R10 data", shadow[8'h21], 8'h32);
      chk(ptr_o == 8'h22, "R10 ptr", ptr_o, 8'h22);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_page();
      t_wrap();
      t_page_edge();
      t_discard();
      t_empty_stop();
      t_busy_ignore();
      t_coincide();
      t_addr_pending();
      finish_run();
   end
endmodule